// File: doc/BRIEF.md
# Input Capture Pulse Timer

This block timestamps transitions of an external input against a free-running tick counter and turns pairs of transitions into an elapsed-time figure. The counter advances on every clock where the tick enable is high and rolls from its top value back to zero. The input first passes through a two-flop synchronizer. Each transition of the polarity chosen by the edge select then copies the live count into the capture output.

Alongside the raw timestamp, the block keeps its own tally of counter roll-overs since the last qualifying edge. When the next qualifying edge arrives, it forms the full elapsed tick count from that tally and the two timestamps. The result stays correct however many times the counter wrapped in between. Selecting one polarity measures the period between like edges. Selecting both polarities measures the length of each high and low phase, one after the other.

Top module: `ic_pulse_timer`

## Requirements
- R1: The tick counter (CNT_W bits, default 16) rises by one on each clock with `tick_en` high, holds while `tick_en` is low, and wraps from 2^CNT_W-1 to 0.
- R2: A level applied to `pin_in` before clock edge k reaches the edge logic through two flops. Any result it causes is registered at edge k+2, and the outputs still show the old values after edge k+1.
- R3: `edge_sel` encoding: 2'b00 qualifies only low-to-high transitions, 2'b01 only high-to-low transitions, and 2'b10 or 2'b11 both. A transition that does not qualify leaves `cap_val`, `width` and `width_vld` unchanged.
- R4: On a qualifying edge, `cap_val` takes the counter value held between edges k+1 and k+2.
- R5: The first qualifying edge after reset only records a start time and raises no `width_vld`.
- R6: Every later qualifying edge loads `width` with the elapsed ticks since the previous qualifying edge, computed as wraps × 2^CNT_W + new capture − old capture on RES_W (default 32) bits.
- R7: `ovf_cnt` restarts on each qualifying edge and then rises by one on every counter wrap until the next qualifying edge.
- R8: If a wrap and a capture fall on the same tick, the captured value is the top count and the wrap is charged to the new interval, so `ovf_cnt` becomes 1. A capture of 0 follows a wrap already charged to the old interval.
- R9: `width_vld` is high for exactly one clock per completed measurement, in the cycle `width` takes its new value.
- R10: While `rst_n` is low, `cap_val`, `ovf_cnt`, `width` and `width_vld` are all zero.
- R11: Clocks with `tick_en` low add nothing to `width` or to the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance enable |
| pin_in | input | 1 | Asynchronous input being timed |
| edge_sel | input | 2 | Polarity select: 00 rise, 01 fall, 1x both |
| cap_val | output | CNT_W | Count latched at the latest qualifying edge |
| ovf_cnt | output | OVF_W | Counter wraps since the latest qualifying edge |
| width | output | RES_W | Elapsed ticks between the last two qualifying edges |
| width_vld | output | 1 | One-clock strobe marking a fresh `width` |

## Verification
A pin change driven at a falling clock edge registers its capture, width and strobe three rising edges later. The bench takes a snapshot of its own tick tally after the second rising edge and compares the outputs at the falling edge after the third. At the snapshot point it also checks that `width_vld` is still low, and one falling edge later it checks that the strobe has dropped. The expected values of `ovf_cnt` and `width` come from the difference between the bench's tick totals divided by the wrap length. The bench uses a 10-bit counter so that single wraps, many wraps and same-tick wraps are all reached within a short run.

// File: rtl/ic_pkg.sv
package ic_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE    = 2'b00,
    EDGE_FALL    = 2'b01,
    EDGE_ANY     = 2'b10,
    EDGE_ANY_ALT = 2'b11
  } edge_mode_t;

  localparam int SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/ic_pin_sync.sv
module ic_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic lvl,
  output logic lvl_d
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl   = chain_q[STAGES-1];
  assign lvl_d = last_q;
endmodule

// File: rtl/ic_edge_qual.sv
module ic_edge_qual
  import ic_pkg::*;
(
  input  logic       lvl,
  input  logic       lvl_d,
  input  logic [1:0] edge_sel,
  output logic       edge_evt
);
  logic rise, fall;
  edge_mode_t mode;

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
  assign mode = edge_mode_t'(edge_sel);

  always_comb begin
    unique case (mode)
      EDGE_RISE: edge_evt = rise;
      EDGE_FALL: edge_evt = fall;
      default:   edge_evt = rise | fall;
    endcase
  end
endmodule

// File: rtl/ic_tick_counter.sv
module ic_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt      = cnt_q;
  assign wrap_evt = tick_en && (cnt_q == TOP);
endmodule

// File: rtl/ic_capture_core.sv
module ic_capture_core #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 16,
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_evt,
  input  logic             wrap_evt,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic [OVF_W-1:0] ovf_cnt,
  output logic [RES_W-1:0] width,
  output logic             width_vld,
  output logic             armed
);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  // full elapsed time: whole wraps plus the signed in-cycle difference
  function automatic logic [RES_W-1:0] span_ticks(
    input logic [OVF_W-1:0] wraps,
    input logic [CNT_W-1:0] stop_at,
    input logic [CNT_W-1:0] start_at
  );
    return (RES_W'(wraps) << CNT_W) + RES_W'(stop_at) - RES_W'(start_at);
  endfunction

  logic [CNT_W-1:0] cap_q;
  logic [OVF_W-1:0] ovf_q;
  logic [RES_W-1:0] width_q;
  logic             vld_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      ovf_q   <= '0;
      width_q <= '0;
      vld_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (edge_evt) begin
        cap_q   <= cnt;
        armed_q <= 1'b1;
        // a wrap on the capture tick follows the top count: new interval
        ovf_q   <= wrap_evt ? OVF_W'(1) : '0;
        if (armed_q) begin
          width_q <= span_ticks(ovf_q, cnt, cap_q);
          vld_q   <= 1'b1;
        end
      end else if (wrap_evt && ovf_q != OVF_MAX) begin
        ovf_q <= ovf_q + 1'b1;
      end
    end
  end

  assign cap_val   = cap_q;
  assign ovf_cnt   = ovf_q;
  assign width     = width_q;
  assign width_vld = vld_q;
  assign armed     = armed_q;
endmodule

// File: rtl/ic_pulse_timer.sv
module ic_pulse_timer #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 16,
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             pin_in,
  input  logic [1:0]       edge_sel,
  output logic [CNT_W-1:0] cap_val,
  output logic [OVF_W-1:0] ovf_cnt,
  output logic [RES_W-1:0] width,
  output logic             width_vld
);
  localparam int SYNC_N = ic_pkg::SYNC_STAGES_DEF;

  // named internal events, observed by the bound checker
  logic [CNT_W-1:0] cnt_now;
  logic             wrap_evt;
  logic             edge_evt;
  logic             armed;
  logic             lvl, lvl_d;

  ic_pin_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl(lvl), .lvl_d(lvl_d)
  );

  ic_edge_qual u_qual (
    .lvl(lvl), .lvl_d(lvl_d), .edge_sel(edge_sel), .edge_evt(edge_evt)
  );

  ic_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt(cnt_now), .wrap_evt(wrap_evt)
  );

  ic_capture_core #(.CNT_W(CNT_W), .OVF_W(OVF_W), .RES_W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .wrap_evt(wrap_evt),
    .cnt(cnt_now), .cap_val(cap_val), .ovf_cnt(ovf_cnt), .width(width),
    .width_vld(width_vld), .armed(armed)
  );
endmodule

// File: rtl/ic_pulse_timer_chk.sv
module ic_pulse_timer_chk #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 16,
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             edge_evt,
  input logic             wrap_evt,
  input logic             armed,
  input logic [CNT_W-1:0] cnt_now,
  input logic [CNT_W-1:0] cap_val,
  input logic [OVF_W-1:0] ovf_cnt,
  input logic [RES_W-1:0] width,
  input logic             width_vld
);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  a_r1_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt_now == CNT_W'($past(cnt_now) + 1'b1));

  a_r1_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_now));

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> cap_val == $past(cnt_now));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_evt |=> $stable(cap_val) && $stable(width));

  // R7 restart and R8 same-tick crediting
  a_r8_ovf_restart: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> ovf_cnt == OVF_W'($past(wrap_evt)));

  a_r7_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_evt && wrap_evt && ovf_cnt != OVF_MAX) |=> ovf_cnt == OVF_W'($past(ovf_cnt) + 1'b1));

  a_r7_ovf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_evt && !wrap_evt) |=> $stable(ovf_cnt));

  a_r9_vld_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && armed) |=> width_vld);

  a_r5_vld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_evt && armed) |=> !width_vld);
endmodule

bind ic_pulse_timer ic_pulse_timer_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .edge_evt(edge_evt),
  .wrap_evt(wrap_evt), .armed(armed), .cnt_now(cnt_now), .cap_val(cap_val),
  .ovf_cnt(ovf_cnt), .width(width), .width_vld(width_vld)
);

// File: tb/tb_ic_pulse_timer.sv
`timescale 1ns/1ps
module tb_ic_pulse_timer;
  localparam int CW = 10;
  localparam int OW = 16;
  localparam int RW = 32;
  localparam longint WRAP = 64'd1 << CW;
  localparam int NV = 12;
  // {edge_sel, gap in clocks, clocks with tick_en low at start of gap}
  localparam int VEC [NV][3] = '{
    '{2, 20, 0}, '{2, 5, 0}, '{2, 300, 0}, '{2, 1500, 0},
    '{2, 5000, 100}, '{2, 2, 0}, '{0, 40, 0}, '{0, 40, 0},
    '{0, 900, 0}, '{1, 30, 0}, '{1, 2100, 7}, '{1, 50, 0}
  };

  logic clk = 1'b0;
  logic rst_n, tick_en, pin_in;
  logic [1:0]    edge_sel;
  logic [CW-1:0] cap_val;
  logic [OW-1:0] ovf_cnt;
  logic [RW-1:0] width;
  logic          width_vld;

  always #2.5 clk = ~clk;

  ic_pulse_timer #(.CNT_W(CW), .OVF_W(OW), .RES_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pin_in(pin_in),
    .edge_sel(edge_sel), .cap_val(cap_val), .ovf_cnt(ovf_cnt),
    .width(width), .width_vld(width_vld)
  );

  // bench tally of ticks since reset
  longint total;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) total <= 0;
    else if (tick_en) total <= total + 1;

  int n_vec = 0, n_bad = 0;
  bit armed_m = 1'b0;
  bit done = 1'b0;
  longint snap_prev = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit qualifies(input int mode, input logic lvl);
    if (mode == 0) return lvl == 1'b1;
    if (mode == 1) return lvl == 1'b0;
    return 1'b1;
  endfunction

  task automatic toggle(input int gap, input int gate, input int mode);
    logic [CW-1:0] old_cap;
    logic [RW-1:0] old_w;
    longint snap, wraps_exp;
    bit q;
    edge_sel = mode[1:0];
    for (int c = 0; c < gap; c++) begin
      @(negedge clk);
      tick_en = (c < gate) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b1;
    if (armed_m) begin
      wraps_exp = (total / WRAP) - (snap_prev / WRAP);
      chk(ovf_cnt == OW'(wraps_exp), "R7 wraps since capture", ovf_cnt, wraps_exp);
    end
    pin_in  = ~pin_in;
    q       = qualifies(mode, pin_in);
    old_cap = cap_val;
    old_w   = width;
    @(negedge clk);
    @(negedge clk);
    snap = total;
    chk(!width_vld, "R2 no result before third edge", width_vld, 0);
    @(negedge clk);
    if (q) begin
      chk(cap_val == CW'(snap), "R4 captured count", cap_val, snap % WRAP);
      if (armed_m) begin
        chk(width_vld, "R9 strobe with result", width_vld, 1);
        chk(width == RW'(snap - snap_prev), "R6/R11 elapsed ticks", width, snap - snap_prev);
      end else begin
        chk(!width_vld, "R5 first edge only arms", width_vld, 0);
      end
      wraps_exp = (total / WRAP) - (snap / WRAP);
      chk(ovf_cnt == OW'(wraps_exp), "R7 restart on capture", ovf_cnt, wraps_exp);
      armed_m   = 1'b1;
      snap_prev = snap;
    end else begin
      chk(!width_vld, "R3 ignored edge strobe", width_vld, 0);
      chk(cap_val == old_cap, "R3 ignored edge capture", cap_val, old_cap);
      chk(width == old_w, "R3 ignored edge width", width, old_w);
    end
    @(negedge clk);
    chk(!width_vld, "R9 strobe one clock", width_vld, 0);
  endtask

  task automatic align(input longint resid);
    do @(negedge clk); while ((total % WRAP) != resid);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; pin_in = 1'b0; edge_sel = 2'b10;
    repeat (4) @(negedge clk);
    chk(cap_val == 0, "R10 reset capture", cap_val, 0);
    chk(ovf_cnt == 0, "R10 reset wraps", ovf_cnt, 0);
    chk(width == 0, "R10 reset width", width, 0);
    chk(!width_vld, "R10 reset strobe", width_vld, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(total == 3 && cap_val == 0, "R1 no capture without edge", cap_val, 0);

    for (int i = 0; i < NV; i++) toggle(VEC[i][1], VEC[i][2], VEC[i][0]);

    // R8: capture lands on the top count with a wrap on the same tick
    edge_sel = 2'b10;
    align(WRAP - 4);
    toggle(0, 0, 2);
    chk(cap_val == CW'(WRAP - 1), "R8 top count captured", cap_val, WRAP - 1);
    chk(ovf_cnt == 1, "R8 wrap charged to new interval", ovf_cnt, 1);
    toggle(10, 0, 2);
    // R8: capture of zero right after a wrap
    align(WRAP - 3);
    toggle(0, 0, 2);
    chk(cap_val == 0, "R8 zero captured", cap_val, 0);
    chk(ovf_cnt == 0, "R8 wrap charged to old interval", ovf_cnt, 0);
    toggle(1030, 0, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule